// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two levels of state. The first level is a set of history shift registers, each recording the most recent outcomes as taken or not taken. The second level is a table of two-bit saturating counters, and the selected history value indexes it. Three organisations are chosen by parameter: one history register shared by every branch feeding one counter table; per-address history registers feeding one shared counter table; and per-address history registers, each with a private counter table. All three use the same datapath, and only the index formation changes.

The fetch stage presents a branch address on the lookup port and receives the predicted direction in the same cycle. This is a combinational read of registered state. When the branch resolves, the execute stage presents its address and actual outcome on the resolve port. On the next clock edge the selected counter moves toward the outcome and the outcome is shifted into the selected history register. A lookup made in the same cycle as a resolve sees the state from before that update.

Top module: `tlap_predictor`

## Requirements
- R1: After reset every history register holds zero and every counter holds 1 (weakly not-taken), so every lookup address predicts not-taken and one taken resolve at a history value makes that value predict taken.
- R2: `lk_taken` is 1 exactly when the selected counter is 2 or 3.
- R3: A taken resolve increments the selected counter and saturates at 3. A not-taken resolve decrements it and saturates at 0.
- R4: On a resolve the selected history register becomes its old value shifted left by one, with the outcome (1 = taken) in bit 0 and the oldest bit dropped.
- R5: The counter updated by a resolve is the one indexed by the history value from before that resolve's shift.
- R6: With `MODE` = 0 a single history register and one table of 2^`HIST_W` counters, indexed by the history value, serve every address.
- R7: With `MODE` = 1 or 2 the history register is selected by address bits [`PC_LSB` +: `GRP_BITS`]. A resolve changes only that group's history register.
- R8: With `MODE` = 2 the counter index is {address bits [`PC_LSB` +: `GRP_BITS`], history}, with the group bits on top. Groups never share a counter. With `MODE` = 1 the index is the history alone.
- R9: A cycle without `rs_valid` changes no state, whatever `rs_pc`, `rs_taken` and `lk_pc` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest case to reach from the ports is the one where the counter at the pre-shift history differs from the counter at the post-shift history. A bug that updates the wrong one can still look correct for a long time. The stimulus resolves one taken outcome at history zero and then enough not-taken outcomes to bring the history back to zero, and only then looks up the address. The bench then runs the three organisations side by side, with a small history width and group count, and drives long loop-like outcome patterns across many addresses. This makes counters saturate, makes groups alias or stay apart, and makes history values wrap. Every lookup is compared with an arithmetic model of the two tables.

// File: rtl/tlap_predictor.sv
module tlap_predictor #(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 11,
  parameter int GRP_BITS = 4,
  parameter int MODE     = 0,
  parameter int PC_LSB   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken
);
  localparam int GB   = (MODE == 0) ? 0 : GRP_BITS;
  localparam int HI_W = (GB == 0) ? 1 : GB;
  localparam int NHR  = 1 << GB;
  localparam int PB   = (MODE == 2) ? GRP_BITS : 0;
  localparam int PI_W = HIST_W + PB;
  localparam int NPT  = 1 << PI_W;

  logic [NHR-1:0][HIST_W-1:0] hrt;
  logic [NPT-1:0][1:0]        ctr;

  logic [HI_W-1:0]   lk_hidx, rs_hidx;
  logic [HIST_W-1:0] lk_hist, rs_hist_old;
  logic [PI_W-1:0]   lk_pidx, rs_pidx;
  logic [1:0]        rs_ctr_old, rs_ctr_nxt;

  wire unused_pc = ^{lk_pc, rs_pc};

  if (GB == 0) begin : g_one_hist
    assign lk_hidx = '0;
    assign rs_hidx = '0;
  end else begin : g_grp_hist
    assign lk_hidx = lk_pc[PC_LSB +: HI_W];
    assign rs_hidx = rs_pc[PC_LSB +: HI_W];
  end

  assign lk_hist     = hrt[lk_hidx];
  assign rs_hist_old = hrt[rs_hidx];

  if (PB == 0) begin : g_shared_pt
    assign lk_pidx = lk_hist;
    assign rs_pidx = rs_hist_old;
  end else begin : g_private_pt
    assign lk_pidx = {lk_pc[PC_LSB +: PB], lk_hist};
    assign rs_pidx = {rs_pc[PC_LSB +: PB], rs_hist_old};
  end

  assign lk_taken   = ctr[lk_pidx][1];
  assign rs_ctr_old = ctr[rs_pidx];

  always_comb begin
    if (rs_taken) rs_ctr_nxt = (rs_ctr_old == 2'd3) ? 2'd3 : rs_ctr_old + 2'd1;
    else          rs_ctr_nxt = (rs_ctr_old == 2'd0) ? 2'd0 : rs_ctr_old - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrt <= '0;
      ctr <= {NPT{2'b01}};
    end else if (rs_valid) begin
      hrt[rs_hidx] <= {rs_hist_old[HIST_W-2:0], rs_taken};
      ctr[rs_pidx] <= rs_ctr_nxt;
    end
  end
endmodule

module tlap_predictor_chk #(
  parameter int HIST_W = 11,
  parameter int NHR    = 1,
  parameter int HI_W   = 1,
  parameter int PI_W   = 11,
  parameter int NPT    = 2048
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rs_valid,
  input logic                       rs_taken,
  input logic [HI_W-1:0]            rs_hidx,
  input logic [PI_W-1:0]            rs_pidx,
  input logic [HIST_W-1:0]          rs_hist_old,
  input logic [1:0]                 rs_ctr_old,
  input logic [NHR-1:0][HIST_W-1:0] hrt,
  input logic [NPT-1:0][1:0]        ctr
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hrt == '0) && (ctr == {NPT{2'b01}})); // R1
  AST_CTR_INC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken) |=> ctr[$past(rs_pidx)] == (($past(rs_ctr_old) == 2'd3) ? 2'd3 : $past(rs_ctr_old) + 2'd1)); // R3
  AST_CTR_DEC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken) |=> ctr[$past(rs_pidx)] == (($past(rs_ctr_old) == 2'd0) ? 2'd0 : $past(rs_ctr_old) - 2'd1)); // R3
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> hrt[$past(rs_hidx)] == {$past(rs_hist_old[HIST_W-2:0]), $past(rs_taken)}); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(hrt) && $stable(ctr)); // R9
endmodule

bind tlap_predictor tlap_predictor_chk #(
  .HIST_W(HIST_W), .NHR(NHR), .HI_W(HI_W), .PI_W(PI_W), .NPT(NPT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rs_valid(rs_valid), .rs_taken(rs_taken),
  .rs_hidx(rs_hidx), .rs_pidx(rs_pidx), .rs_hist_old(rs_hist_old),
  .rs_ctr_old(rs_ctr_old), .hrt(hrt), .ctr(ctr)
);

// File: tb/sim_tlap_predictor.sv
module sim_tlap_predictor;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] lk_pc = '0, rs_pc = '0;
  logic       rs_valid = 0, rs_taken = 0;
  logic       p0, p1, p2;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  int mh[3][4];
  int mc[3][32];

  always #4 clk = ~clk;

  tlap_predictor #(.PC_W(8), .HIST_W(3), .GRP_BITS(2), .MODE(0), .PC_LSB(2)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p0),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));
  tlap_predictor #(.PC_W(8), .HIST_W(3), .GRP_BITS(2), .MODE(1), .PC_LSB(2)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p1),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));
  tlap_predictor #(.PC_W(8), .HIST_W(3), .GRP_BITS(2), .MODE(2), .PC_LSB(2)) u2 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p2),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

  function automatic int hsel(int k, int pc);
    return (k == 0) ? 0 : ((pc >> 2) & 3);
  endfunction

  function automatic int psel(int k, int pc, int h);
    return (k == 2) ? ((((pc >> 2) & 3) << 3) | h) : h;
  endfunction

  function automatic logic got_of(int k);
    return (k == 0) ? p0 : (k == 1) ? p1 : p2;
  endfunction

  task automatic look(input int pc, input string tag);
    lk_pc = 8'(pc);
    #1;
    for (int k = 0; k < 3; k++) begin
      logic e;
      e = (mc[k][psel(k, pc, mh[k][hsel(k, pc)])] >= 2);
      n_run++;
      if (got_of(k) !== e) begin
        n_fail++;
        $display("FAIL %s mode%0d pc=%0d actual=%0b expected=%0b", tag, k, pc, got_of(k), e);
      end
    end
  endtask

  task automatic resolve(input int pc, input bit t);
    for (int k = 0; k < 3; k++) begin
      int g, h, i;
      g = hsel(k, pc);
      h = mh[k][g];
      i = psel(k, pc, h);
      if (t) mc[k][i] = (mc[k][i] == 3) ? 3 : mc[k][i] + 1;
      else   mc[k][i] = (mc[k][i] == 0) ? 0 : mc[k][i] - 1;
      mh[k][g] = ((h << 1) | int'(t)) & 7;
    end
    @(negedge clk);
    rs_pc = 8'(pc); rs_taken = t; rs_valid = 1;
    @(posedge clk);
    #1 rs_valid = 0;
  endtask

  task automatic hard(input logic got, input logic e, input string tag);
    n_run++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lf;
    for (int k = 0; k < 3; k++) begin
      for (int g = 0; g < 4; g++) mh[k][g] = 0;
      for (int i = 0; i < 32; i++) mc[k][i] = 1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int pc = 0; pc < 256; pc += 4) look(pc, "R1 reset");

    // R5: T then N,N,N returns history to 0; only the pre-shift counter 0 was raised
    resolve(0, 1);
    for (int j = 0; j < 3; j++) resolve(0, 0);
    lk_pc = 8'd0; #1;
    hard(p0, 1'b1, "R5 global pre-shift index");
    hard(p2, 1'b1, "R5 private pre-shift index");
    look(0, "R5");
    lk_pc = 8'd4; #1;
    hard(p1, 1'b1, "R8 shared table seen by group1");
    hard(p2, 1'b0, "R8 private table of group1");

    resolve(4, 1);
    for (int pc = 0; pc < 64; pc += 4) look(pc, "R6 R7 R8 grouping");

    for (int j = 0; j < 12; j++) resolve(8, 1);
    look(8, "R3 saturate high");
    for (int j = 0; j < 12; j++) resolve(8, 0);
    look(8, "R3 saturate low");
    resolve(8, 1);
    look(8, "R1 R2 weak step");

    @(negedge clk);
    for (int j = 0; j < 20; j++) begin
      rs_pc = 8'(j * 4); rs_taken = j[0]; lk_pc = 8'(j * 12);
      @(negedge clk);
    end
    for (int pc = 0; pc < 256; pc += 4) look(pc, "R9 idle hold");

    lf = 32'h1d3;
    for (int it = 0; it < 3000; it++) begin
      int pc;
      bit t;
      lf = ((lf << 1) | (((lf >> 8) ^ (lf >> 4)) & 1)) & 16'h1ff;
      pc = (lf & 15) * 4;
      t = ((it % 5) != 4) ^ (((lf >> 5) & 7) == 0);
      look(pc, "R2 R3 R4 sweep");
      resolve(pc, t);
    end
    for (int pc = 0; pc < 256; pc += 4) look(pc, "R6 R7 R8 final");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule